// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects an internal request port to an external asynchronous static RAM of 2M words by 16 bits. A requester offers an address, a write flag, a two-bit byte mask and write data under a valid/ready handshake. The controller turns each request into a timed sequence on the memory pins. These pins are the active-low chip select, write enable and output enable, plus an active-low strobe for each byte lane. Read data comes back on a response port with a one-cycle valid pulse.

The data bus is split into three signals: the value to drive, a drive enable for the pad cell, and the sampled input. The controller drives the bus only while a write is in progress. It never asks the memory to drive while it drives itself. After reset it waits for the memory's power-up interval, given in microseconds and converted to clock cycles, before it accepts any request. Each strobe phase lasts a whole number of clock cycles that covers the memory access time.

Top module: `sram_ctrl`

## Requirements
- R1: After reset release, `req_ready_o` stays low and `sram_cs_no` stays high until the power-up wait ends. The wait is PWRUP_CYC = PWRUP_US*CLK_KHZ/1000 cycles. `req_ready_o` first reads high after exactly PWRUP_CYC+1 rising edges. Requests offered during the wait are dropped and leave the memory untouched.
- R2: During reset and while the controller is idle, `sram_cs_no`, `sram_we_no`, `sram_oe_no`, `sram_ub_no` and `sram_lb_no` are all high, and `sram_dq_oe_o` is low.
- R3: A read with a nonzero mask holds `sram_cs_no` low, `sram_we_no` high and `sram_oe_no` low for ACC_CYC+1 cycles. `sram_dq_i` is sampled on the last edge of that window. `rsp_valid_o` is high for one cycle, A+1 rising edges after the accepting edge, where A = ACC_CYC. In that cycle the chip select is already high.
- R4: A write with a nonzero mask first spends one setup cycle with chip select low and write enable high. Write enable is then low for ACC_CYC cycles. One recovery cycle follows with write enable high, chip select low and the bus still driven. The bus is then released and chip select goes high, so chip select is low for ACC_CYC+2 cycles.
- R5: `sram_dq_oe_o` is high only while chip select is low and output enable is high. Output enable is low only while write enable is high.
- R6: Mask bit 0 selects lane bits 7:0 and `sram_lb_no`. Mask bit 1 selects bits 15:8 and `sram_ub_no`. A write changes only the lanes whose mask bits are set, and the full 21-bit address reaches `sram_addr_o`.
- R7: In read data, any lane whose mask bit is clear returns zero.
- R8: A request with an all-zero mask never asserts chip select. A zero-mask read returns `rsp_valid_o` with zero data in the cycle after the accepting edge. A zero-mask write has no effect. Ready stays high in both cases.
- R9: While chip select is held low, the address, byte strobes and driven write data do not change.
- R10: `req_ready_o` is low from the accepting edge until the access ends. Requests offered while busy are ignored. After a read, ready is high in the same cycle as `rsp_valid_o`. After a write, ready is high ACC_CYC+2 edges after the accepting edge.
- R11: ACC_CYC = ceil(ACCESS_NS*CLK_KHZ/1e6), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Word address |
| req_be_i | input | 2 | Byte mask, bit 0 = low lane |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data |
| sram_addr_o | output | 21 | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_ub_no | output | 1 | Upper byte strobe, active low |
| sram_lb_no | output | 1 | Lower byte strobe, active low |
| sram_dq_o | output | 16 | Data to drive onto the bus |
| sram_dq_oe_o | output | 1 | Pad drive enable |
| sram_dq_i | input | 16 | Data sampled from the bus |

## Verification
All inputs are applied just after the falling edge, and outputs are read one time step after a falling edge, so every reading reflects a whole number of rising edges counted from the accepting edge. The bench is built with A = 3. A read response is due at A+1 edges, a write returns ready at A+2 edges, a zero-mask read answers after the accepting edge itself, and ready first appears PWRUP_CYC+1 edges after reset release. A pin monitor runs on the same falling-edge grid and measures the length of the write-enable and chip-select windows. A memory model stores lanes when write enable rises and drives filler onto unstrobed lanes, so lane masking and zero fill can be seen at the response port.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned NLANES  = DW / LANE_W;
  localparam int unsigned LANE_LO = 0;
  localparam int unsigned LANE_HI = 1;

  typedef enum logic [2:0] {
    ST_INIT_WAIT,
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrl_state_e;

  function automatic logic st_is_read(ctrl_state_e s);
    return (s == ST_RD_ACCESS) || (s == ST_RD_CAPTURE);
  endfunction

  function automatic logic st_is_write(ctrl_state_e s);
    return (s == ST_WR_SETUP) || (s == ST_WR_PULSE) || (s == ST_WR_RECOVER);
  endfunction

  function automatic logic st_is_active(ctrl_state_e s);
    return st_is_read(s) || st_is_write(s);
  endfunction
endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
  parameter int unsigned CYCLES = 7500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'((CYCLES == 0) ? 0 : CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  assert_done_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'((CYCLES == 0) ? 0 : CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_lanes.sv
module sram_rd_lanes #(
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [LANES-1:0]   lane_en_i,
  input  logic [LANES*LW-1:0] dq_i,
  output logic [LANES*LW-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q <= '0;
      else if (capture_i) lane_q <= lane_en_i[g] ? dq_i[g*LW +: LW] : '0;
    end
    assign rdata_o[g*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 21,
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned PWRUP_US  = 150,
  parameter int unsigned ACCESS_NS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [NLANES-1:0] req_be_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [AW-1:0]     sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_ub_no,
  output logic              sram_lb_no,
  output logic [DW-1:0]     sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DW-1:0]     sram_dq_i
);
  localparam int unsigned PWRUP_CYC = PWRUP_US * CLK_KHZ / 1000;
  localparam int unsigned ACC_RAW   = (ACCESS_NS * CLK_KHZ + 999_999) / 1_000_000;
  localparam int unsigned ACC_CYC   = (ACC_RAW == 0) ? 1 : ACC_RAW;

  ctrl_state_e state_q, state_d;
  logic pwr_done, ph_start, ph_expired;
  logic accept, zero_mask, start_acc, zero_rd, capture;
  logic [NLANES-1:0] be_q, be_d, lane_en, rsp_be_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic cs_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q;
  logic [NLANES-1:0] strb_n_q, strb_n_d;

  sram_pwrup_timer #(.CYCLES(PWRUP_CYC)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pwr_done)
  );

  sram_phase_timer #(.CYCLES(ACC_CYC)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ph_start),
    .expired_o (ph_expired)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign zero_mask   = (req_be_i == '0);
  assign start_acc   = accept && !zero_mask;
  assign zero_rd     = accept && zero_mask && !req_we_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT_WAIT:  if (pwr_done) state_d = ST_IDLE;
      ST_IDLE:       if (start_acc) state_d = req_we_i ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (ph_expired) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_IDLE;
      ST_WR_SETUP:   state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (ph_expired) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Phase timer loads on entry to either strobe phase.
  assign ph_start = (start_acc && !req_we_i) || (state_q == ST_WR_SETUP);

  assign be_d = start_acc ? req_be_i : be_q;

  for (genvar g = 0; g < NLANES; g++) begin : g_strb
    assign strb_n_d[g] = !(st_is_active(state_d) && be_d[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT_WAIT;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start_acc) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  // Pin controls registered from the next state: no decode glitches at the pads.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      strb_n_q <= '1;
    end else begin
      cs_n_q   <= !st_is_active(state_d);
      we_n_q   <= (state_d != ST_WR_PULSE);
      oe_n_q   <= !st_is_read(state_d);
      dq_oe_q  <= st_is_write(state_d);
      strb_n_q <= strb_n_d;
    end
  end

  assign capture = (state_q == ST_RD_CAPTURE) || zero_rd;
  assign lane_en = (state_q == ST_RD_CAPTURE) ? be_q : '0;

  sram_rd_lanes #(.LANES(NLANES), .LW(LANE_W)) u_lanes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .lane_en_i (lane_en),
    .dq_i      (sram_dq_i),
    .rdata_o   (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_be_q    <= '0;
    end else begin
      rsp_valid_q <= capture;
      if (capture) rsp_be_q <= lane_en;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = dq_oe_q;
  assign sram_cs_no   = cs_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_lb_no   = strb_n_q[LANE_LO];
  assign sram_ub_no   = strb_n_q[LANE_HI];

  assert_init_no_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT_WAIT) |-> sram_cs_no);

  assert_idle_pins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_cs_no && sram_we_no && sram_oe_no && !sram_dq_oe_o
                     && sram_ub_no && sram_lb_no));

  assert_rsp_standby_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> sram_cs_no);

  assert_we_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(!sram_cs_no));

  assert_bus_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_cs_no));

  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_oe_no && !sram_cs_no));

  assert_oe_needs_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> sram_we_no);

  for (genvar g = 0; g < NLANES; g++) begin : g_chk
    assert_zero_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_be_q[g]) |-> (rsp_rdata_o[g*LANE_W +: LANE_W] == '0));
  end

  assert_zero_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && zero_mask) |=> sram_cs_no);

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |->
      ($stable(sram_addr_o) && $stable(sram_ub_no) && $stable(sram_lb_no)
       && $stable(sram_dq_o)));

  assert_busy_not_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_no |-> !req_ready_o);
endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int CLK_KHZ   = 50000;
  localparam int PWRUP_US  = 150;
  localparam int ACCESS_NS = 50;
  localparam int PWRUP     = PWRUP_US * CLK_KHZ / 1000;                 // 7500
  localparam int ACC       = (ACCESS_NS * CLK_KHZ + 999999) / 1000000;  // 3

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic ready, rsp_valid, cs_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [20:0] addr;

  always #10 clk = ~clk;

  sram_ctrl #(.AW(21), .CLK_KHZ(CLK_KHZ), .PWRUP_US(PWRUP_US), .ACCESS_NS(ACCESS_NS)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .sram_addr_o(addr), .sram_cs_no(cs_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_ub_no(ub_n), .sram_lb_no(lb_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // memory model, 256 words indexed by the low address byte
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  wire rd_on = !cs_n && we_n && !oe_n;
  assign dq_i = {(rd_on && !ub_n) ? mem[addr[7:0]][15:8] : 8'hEE,
                 (rd_on && !lb_n) ? mem[addr[7:0]][7:0]  : 8'hEE};

  int n_checks = 0, n_fail = 0;
  bit in_init = 0, finished = 0;
  int v_cont = 0, v_init = 0, v_stab = 0, v_setup = 0, v_hold = 0;
  int we_run = 0, cs_run = 0, we_len = 0, cs_len = 0, cs_falls = 0;
  logic [20:0] last_wr_addr = '0, prev_addr = '0;
  logic [1:0]  prev_strb = '1;
  logic [15:0] prev_dq = '0;
  bit prev_cs_low = 0, prev_we_low = 0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = {~i[7:0], i[7:0]};
    shadow[i] = {~i[7:0], i[7:0]};
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && !oe_n) v_cont++;
      if (!oe_n && !we_n) v_cont++;
      if (dq_oe && cs_n) v_cont++;
      if (in_init && !cs_n) v_init++;
      if (!cs_n && prev_cs_low && (addr != prev_addr || {ub_n, lb_n} != prev_strb || dq_o != prev_dq)) v_stab++;
      if (!we_n && !prev_we_low && !prev_cs_low) v_setup++;
      if (we_n && prev_we_low) begin
        if (!cs_n && dq_oe) begin
          if (!lb_n) mem[addr[7:0]][7:0]  = dq_o[7:0];
          if (!ub_n) mem[addr[7:0]][15:8] = dq_o[15:8];
          last_wr_addr = addr;
        end else v_hold++;
        we_len = we_run; we_run = 0;
      end
      if (!we_n) we_run++;
      if (!cs_n && !prev_cs_low) cs_falls++;
      if (cs_n && prev_cs_low) begin cs_len = cs_run; cs_run = 0; end
      if (!cs_n) cs_run++;
      prev_cs_low = !cs_n; prev_we_low = !we_n;
      prev_addr = addr; prev_strb = {ub_n, lb_n}; prev_dq = dq_o;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [20:0] a, input logic [1:0] be);
    return {be[1] ? shadow[a[7:0]][15:8] : 8'h00, be[0] ? shadow[a[7:0]][7:0] : 8'h00};
  endfunction

  task automatic test_reset_init();
    int n;
    rst_n = 1'b0;
    repeat (3) step();
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check({cs_n, we_n, oe_n, ub_n, lb_n, dq_oe} == 6'b111110, "R2 pins in reset",
          {cs_n, we_n, oe_n, ub_n, lb_n, dq_oe}, 6'b111110);
    rst_n = 1'b1; in_init = 1;
    n = 0;
    while (!ready && n < PWRUP + 20) begin
      step(); n++;
      if (n == 100) begin
        req_valid = 1; req_we = 1; req_addr = 21'd5; req_be = 2'b11; req_wdata = 16'h1234;
      end
      if (n == 104) req_valid = 0;
    end
    in_init = 0;
    check(n == PWRUP + 1, "R1 ready after power-up wait", n, PWRUP + 1);
    check(v_init == 0, "R1 no chip select during wait", v_init, 0);
    check({cs_n, we_n, oe_n, ub_n, lb_n, dq_oe} == 6'b111110, "R2 idle pins",
          {cs_n, we_n, oe_n, ub_n, lb_n, dq_oe}, 6'b111110);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [1:0] be, input logic [15:0] d);
    int n;
    req_valid = 1; req_we = 1; req_addr = a; req_be = be; req_wdata = d;
    step();
    req_valid = 0;
    check(ready == 1'b0, "R10 busy after accept", ready, 0);
    n = 0;
    while (!ready && n < 100) begin step(); n++; end
    check(n == ACC + 2, "R10 R11 write completion edges", n, ACC + 2);
    check(we_len == ACC, "R4 R11 write strobe width", we_len, ACC);
    check(cs_len == ACC + 2, "R4 chip select window on write", cs_len, ACC + 2);
    check(last_wr_addr == a, "R6 full address on write", last_wr_addr, a);
    if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    check(mem[a[7:0]] == shadow[a[7:0]], "R6 lanes stored", mem[a[7:0]], shadow[a[7:0]]);
  endtask

  task automatic do_read(input logic [20:0] a, input logic [1:0] be, input string req);
    int n;
    logic [15:0] e;
    e = exp_rd(a, be);
    req_valid = 1; req_we = 0; req_addr = a; req_be = be; req_wdata = 16'hFFFF;
    step();
    req_valid = 0;
    n = 0;
    while (!rsp_valid && n < 100) begin step(); n++; end
    check(n == ACC + 1, "R3 R11 read response edges", n, ACC + 1);
    check(ready == 1'b1, "R10 ready with response", ready, 1);
    check(cs_len == ACC + 1, "R3 chip select window on read", cs_len, ACC + 1);
    check(rdata == e, req, rdata, e);
    step();
    check(rsp_valid == 1'b0, "R3 single-cycle response", rsp_valid, 0);
  endtask

  task automatic do_zero(input bit we, input logic [20:0] a, input logic [15:0] d);
    int falls;
    falls = cs_falls;
    req_valid = 1; req_we = we; req_addr = a; req_be = 2'b00; req_wdata = d;
    step();
    req_valid = 0;
    check(rsp_valid == !we, "R8 zero-mask response", rsp_valid, !we);
    if (!we) check(rdata == 16'h0, "R8 zero-mask read data", rdata, 0);
    check(ready == 1'b1, "R8 ready stays high", ready, 1);
    repeat (3) step();
    check(cs_falls == falls, "R8 no chip select", cs_falls, falls);
    check(mem[a[7:0]] == shadow[a[7:0]], "R8 memory untouched", mem[a[7:0]], shadow[a[7:0]]);
  endtask

  task automatic test_busy_ignore();
    int n;
    req_valid = 1; req_we = 1; req_addr = 21'h77; req_be = 2'b11; req_wdata = 16'h1111;
    step();
    req_addr = 21'h78; req_wdata = 16'h2222;
    n = 0;
    while (!ready && n < 100) begin
      step(); n++;
      if (n == ACC + 1) req_valid = 0;
    end
    req_valid = 0;
    check(n == ACC + 2, "R10 write completes while request held", n, ACC + 2);
    shadow[8'h77] = 16'h1111;
    repeat (2) step();
    check(mem[8'h78] == shadow[8'h78], "R10 busy request ignored", mem[8'h78], shadow[8'h78]);
    do_read(21'h77, 2'b11, "R10 first write landed");
  endtask

  initial begin
    test_reset_init();
    do_write(21'h000012, 2'b11, 16'hBEEF);
    do_read(21'h000012, 2'b11, "R3 full-word read");
    do_write(21'h1FFF34, 2'b01, 16'h5A5A);
    do_read(21'h1FFF34, 2'b11, "R6 low lane write only");
    do_write(21'h0A0056, 2'b10, 16'hC3C3);
    do_read(21'h0A0056, 2'b11, "R6 high lane write only");
    do_read(21'h1FFF34, 2'b01, "R7 upper lane zero");
    do_read(21'h0A0056, 2'b10, "R7 lower lane zero");
    do_zero(1'b1, 21'h000012, 16'h0000);
    do_zero(1'b0, 21'h000012, 16'h0000);
    do_read(21'h000012, 2'b11, "R8 zero-mask write left data");
    do_read(21'h000005, 2'b11, "R1 request during wait dropped");
    test_busy_ignore();
    check(v_cont == 0, "R5 bus contention", v_cont, 0);
    check(v_stab == 0, "R9 held signals changed", v_stab, 0);
    check(v_setup == 0, "R4 write strobe without setup", v_setup, 0);
    check(v_hold == 0, "R4 bus released before strobe end", v_hold, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule